// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two pieces of state. The first is a short global history of the directions taken by the most recently resolved branches. The second is a table of entries indexed by the low bits of the branch address. Each entry holds one 2-bit saturating counter for every possible history value. The current global history picks which counter in the addressed entry gives the answer, and the most significant bit of that counter is the predicted direction.

A fetch stage raises a predict request with a branch address. One cycle later it receives the direction, together with a snapshot of the history that was used. When the branch resolves, the back end returns that address, the snapshot and the real outcome on the update port. The update trains only the counter that the snapshot selects and shifts the outcome into the global history.

After reset, a controller walks the table and writes the weakly-not-taken value into every counter. It has two states. `ST_INIT` steps an index from 0 to the last entry and leaves on the transition "sweep done", which is taken when the last index is written. `ST_RUN` accepts requests and has no exit except reset. The `ready_o` output is high only in `ST_RUN`.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset is released, `ready_o` stays low for exactly 2^IDX_W cycles (256 by default) and then stays high. At that point every counter holds binary 01 and the global history is 00, so every prediction is not-taken with history snapshot 00.
- R2: A predict request accepted while `ready_o` is high produces `pred_valid_o` high exactly one cycle later. In that cycle `pred_hist_o` equals the global history value at the time of the request.
- R3: `pred_taken_o` is bit 1 of the counter found at row `pred_pc_i[IDX_W-1:0]`, column equal to the global history (history value k selects counter k).
- R4: An update with `upd_taken_i`=1 increments the selected counter and saturates at 3. An update with `upd_taken_i`=0 decrements it and saturates at 0.
- R5: An update changes only the counter at row `upd_pc_i[IDX_W-1:0]`, column `upd_hist_i`. The other three counters of that row, and all other rows, keep their values.
- R6: Each accepted update shifts the history left by one position, and `upd_taken_i` enters at bit 0 (new history = {old bit 0, outcome}).
- R7: Only the low IDX_W address bits choose the row. Two addresses that differ only above those bits share all of their counters.
- R8: While `ready_o` is low, update requests change neither the counters nor the history, and predict requests produce no `pred_valid_o`.
- R9: When a predict and an update arrive in the same cycle, the prediction uses the counters and history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ready_o | output | 1 | High once the table sweep has finished |
| pred_valid_i | input | 1 | Predict request |
| pred_pc_i | input | PC_W | Address of the branch to predict |
| pred_valid_o | output | 1 | Prediction result valid (one cycle after the request) |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | History snapshot used for this prediction |
| upd_valid_i | input | 1 | Resolved-branch update request |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_hist_i | input | HIST_W | Snapshot returned with the earlier prediction |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
Prediction and training can fall in the same cycle. The read must then return the counter and history as they were before the write that occurs at the same edge. The bench provokes this in two ways. It issues directed requests in which predict and update name the same row and the same counter. It also runs a long random mix in which both ports are often active together. Each expected result is computed from a reference model before that cycle's update is applied to the model, and the scoreboard compares it with the design's output. The bench also drives both ports during the sweep, and judges that they were ignored from the first predictions made after `ready_o` rises.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'b01;

    typedef enum logic [0:0] {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;

    // Saturating 2-bit counter step
    function automatic ctr_t ctr_train(input ctr_t c, input logic up);
        if (up) begin
            return (c == 2'b11) ? c : c + 2'd1;
        end
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/cbp_init_fsm.sv
module cbp_init_fsm
    import cbp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic             ready,
    output logic             init_we,
    output logic [IDX_W-1:0] init_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    phase_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (idx_q == LAST_IDX) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        init_we = 1'b0;
        unique case (state_q)
            ST_INIT: init_we = 1'b1;
            ST_RUN:  ready   = 1'b1;
            default: ;
        endcase
    end

    assign init_idx = idx_q;

endmodule

// File: rtl/cbp_history.sv
module cbp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= bit_in;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
            end
        end
    endgenerate

    assign hist = hist_q;

endmodule

// File: rtl/cbp_counter_bank.sv
module cbp_counter_bank
    import cbp_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_we,
    input  logic [IDX_W-1:0]  init_idx,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [HIST_W-1:0] upd_sel,
    input  logic              upd_taken,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [HIST_W-1:0] rd_sel,
    output ctr_t              rd_ctr
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int WAYS    = 1 << HIST_W;

    ctr_t way_rd [WAYS];
    ctr_t rd_q;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            ctr_t bank [ENTRIES];
            always_ff @(posedge clk) begin
                if (init_we) begin
                    bank[init_idx] <= CTR_WEAK_NT;
                end else if (upd_we && (upd_sel == HIST_W'(w))) begin
                    bank[upd_idx] <= ctr_train(bank[upd_idx], upd_taken);
                end
            end
            assign way_rd[w] = bank[rd_idx];
        end
    endgenerate

    // registered read returns pre-write contents on a same-edge write
    always_ff @(posedge clk) begin
        if (rst)        rd_q <= CTR_WEAK_NT;
        else if (rd_en) rd_q <= way_rd[rd_sel];
    end

    assign rd_ctr = rd_q;

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
    import cbp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ready_o,
    input  logic              pred_valid_i,
    input  logic [PC_W-1:0]   pred_pc_i,
    output logic              pred_valid_o,
    output logic              pred_taken_o,
    output logic [HIST_W-1:0] pred_hist_o,
    input  logic              upd_valid_i,
    input  logic [PC_W-1:0]   upd_pc_i,
    input  logic [HIST_W-1:0] upd_hist_i,
    input  logic              upd_taken_i
);
    logic              ready_w;
    logic              init_we_w;
    logic [IDX_W-1:0]  init_idx_w;
    logic [HIST_W-1:0] ghr_w;
    logic              pred_go;
    logic              upd_go;
    ctr_t              rd_ctr_w;
    logic              pv_q;
    logic [HIST_W-1:0] ph_q;

    wire unused_hi = &{1'b0, pred_pc_i[PC_W-1:IDX_W], upd_pc_i[PC_W-1:IDX_W]};

    assign pred_go = pred_valid_i && ready_w;
    assign upd_go  = upd_valid_i && ready_w;

    cbp_init_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ready    (ready_w),
        .init_we  (init_we_w),
        .init_idx (init_idx_w)
    );

    cbp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_go),
        .bit_in   (upd_taken_i),
        .hist     (ghr_w)
    );

    cbp_counter_bank #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .init_we   (init_we_w),
        .init_idx  (init_idx_w),
        .upd_we    (upd_go),
        .upd_idx   (upd_pc_i[IDX_W-1:0]),
        .upd_sel   (upd_hist_i),
        .upd_taken (upd_taken_i),
        .rd_en     (pred_go),
        .rd_idx    (pred_pc_i[IDX_W-1:0]),
        .rd_sel    (ghr_w),
        .rd_ctr    (rd_ctr_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q <= 1'b0;
            ph_q <= '0;
        end else begin
            pv_q <= pred_go;
            if (pred_go) ph_q <= ghr_w;
        end
    end

    assign ready_o      = ready_w;
    assign pred_valid_o = pv_q;
    assign pred_taken_o = rd_ctr_w[1];
    assign pred_hist_o  = ph_q;

endmodule

// File: rtl/cbp_chk.sv
module cbp_chk #(
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_o,
    input logic              pred_valid_i,
    input logic              pred_valid_o,
    input logic [HIST_W-1:0] pred_hist_o,
    input logic              upd_valid_i,
    input logic              upd_taken_i,
    input logic [HIST_W-1:0] ghr
);
    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);

    // R2
    pred_latency_chk: assert property (@(posedge clk) disable iff (rst)
        pred_valid_o == $past(pred_valid_i && ready_o));

    // R2
    pred_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        pred_valid_o |-> pred_hist_o == $past(ghr));

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && ready_o) |=> ghr[0] == $past(upd_taken_i));

    // R8
    init_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && upd_valid_i) |=> $stable(ghr));

endmodule

bind corr_branch_predictor cbp_chk #(.HIST_W(HIST_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ready_o      (ready_o),
    .pred_valid_i (pred_valid_i),
    .pred_valid_o (pred_valid_o),
    .pred_hist_o  (pred_hist_o),
    .upd_valid_i  (upd_valid_i),
    .upd_taken_i  (upd_taken_i),
    .ghr          (ghr_w)
);

// File: tb/corr_branch_predictor_test.sv
module corr_branch_predictor_test;
    localparam int CLK_NS  = 10;
    localparam int ENTRIES = 256;

    typedef struct {
        logic       taken;
        logic [1:0] hist;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready_o;
    logic        pred_valid_i = 1'b0;
    logic [31:0] pred_pc_i = '0;
    logic        pred_valid_o;
    logic        pred_taken_o;
    logic [1:0]  pred_hist_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic [1:0]  upd_hist_i = '0;
    logic        upd_taken_i = 1'b0;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    exp_t sb_q[$];

    logic [1:0] mctr [ENTRIES][4];
    logic [1:0] mghr;

    corr_branch_predictor uut (
        .clk(clk), .rst(rst), .ready_o(ready_o),
        .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
        .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
        .pred_hist_o(pred_hist_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
        .upd_hist_i(upd_hist_i), .upd_taken_i(upd_taken_i)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: call at a falling edge; leaves at the next falling edge
    task automatic step(input bit pv, input logic [31:0] ppc, input bit uv,
                        input logic [31:0] upc, input logic [1:0] uh,
                        input bit ut, input string req);
        exp_t e;
        pred_valid_i = pv; pred_pc_i = ppc;
        upd_valid_i = uv; upd_pc_i = upc; upd_hist_i = uh; upd_taken_i = ut;
        if (ready_o) begin
            if (pv) begin
                e.taken = mctr[ppc[7:0]][mghr][1];
                e.hist  = mghr;
                e.req   = req;
                sb_q.push_back(e);
            end
            if (uv) begin
                logic [1:0] c;
                c = mctr[upc[7:0]][uh];
                if (ut) c = (c == 2'd3) ? c : c + 2'd1;
                else    c = (c == 2'd0) ? c : c - 2'd1;
                mctr[upc[7:0]][uh] = c;
                mghr = {mghr[0], ut};
            end
        end
        @(negedge clk);
        pred_valid_i = 1'b0; upd_valid_i = 1'b0;
    endtask

    task automatic upd(input logic [31:0] pc, input bit t, input string req);
        step(0, '0, 1, pc, mghr, t, req);
    endtask

    task automatic pred(input logic [31:0] pc, input string req);
        step(1, pc, 0, '0, '0, 0, req);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && pred_valid_o) begin
            if (sb_q.size() == 0) begin
                check(0, "R2 R8 unexpected pred_valid_o", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(pred_taken_o === e.taken, {e.req, " direction"}, pred_taken_o, e.taken);
                check(pred_hist_o === e.hist, {"R2 ", e.req, " snapshot"}, pred_hist_o, e.hist);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int low_cnt;
        for (int i = 0; i < ENTRIES; i++)
            for (int j = 0; j < 4; j++) mctr[i][j] = 2'b01;
        mghr = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and sweep length; R8 requests during sweep ignored
        check(ready_o === 1'b0, "R1 ready low after reset", ready_o, 0);
        low_cnt = 0;
        while (ready_o !== 1'b1 && low_cnt < 1000) begin
            low_cnt++;
            step(1, 32'h5, 1, 32'h5, 2'd1, 1, "R8");
        end
        check(low_cnt == ENTRIES, "R1 sweep cycles", low_cnt, ENTRIES);
        // R1 / R8: all weak not-taken, history still 00
        pred(32'h5, "R1 R8");
        pred(32'h0, "R1");
        pred(32'hFF, "R1");
        pred(32'h1234, "R1 R3");
        // R4 saturation upward on counter column 0 of row 0x40
        repeat (4) step(0, '0, 1, 32'h40, 2'd0, 1, "R4");
        upd(32'h80, 0, "R6"); upd(32'h80, 0, "R6");
        pred(32'h40, "R3 R4");
        // R4 downward saturation then recover
        repeat (5) step(0, '0, 1, 32'h40, 2'd0, 0, "R4");
        pred(32'h40, "R4");
        step(0, '0, 1, 32'h40, 2'd0, 1, "R4");
        pred(32'h40, "R4");
        step(0, '0, 1, 32'h40, 2'd0, 1, "R4");
        pred(32'h40, "R4");
        // R5 other columns of row 0x40 untouched
        upd(32'h99, 1, "R6"); pred(32'h40, "R5");
        upd(32'h99, 1, "R6"); pred(32'h40, "R5");
        upd(32'h99, 0, "R6"); pred(32'h40, "R5");
        // R6 history shift visible in snapshot
        upd(32'h7, 1, "R6"); upd(32'h7, 0, "R6"); pred(32'h7, "R6");
        // R7 aliasing rows
        repeat (3) step(0, '0, 1, 32'h10, mghr, 1, "R7");
        pred(32'h110, "R7");
        pred(32'hABCD0010, "R7");
        // R9 same-cycle predict and update on the same counter
        step(1, 32'h10, 1, 32'h10, mghr, 0, "R9");
        step(1, 32'h10, 1, 32'h10, mghr, 0, "R9");
        step(1, 32'h10, 1, 32'h10, mghr, 0, "R9");
        pred(32'h10, "R9");
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] pa, ua;
            pa = {$urandom_range(3, 0) << 8, 8'($urandom_range(15, 0))};
            ua = {$urandom_range(3, 0) << 8, 8'($urandom_range(15, 0))};
            step($urandom_range(1, 0), pa, $urandom_range(1, 0), ua,
                 2'($urandom_range(3, 0)), $urandom_range(1, 0), "R3 R4 R5 R9");
        end
        @(negedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "R2 missing results", sb_q.size(), 0);
        finish_run();
    end

endmodule